// File: doc/BRIEF.md
# Group Handshake Sequencer

This block is a control state machine that runs a group of child units on behalf of a parent, using a four-phase valid/ready handshake on every link. The parent raises `start_val` and holds it. The controller then activates its children. When the whole group has finished, it raises `done_rdy` and keeps it high until the parent lowers `start_val`. Only after that does it go back to idle and accept the next request.

A parameter chooses how the children are activated. In concurrent mode every child is given valid in the same cycle. A child's ready is remembered once it has been seen, so children that finish in different cycles still count as done. In ordered mode the children are activated one at a time, from index 0 upward. The controller moves to the next child only after the current child reports ready. Children are expected to hold their ready until their valid drops.

Top module: `grp_handshake_ctrl`

## Requirements
- R1: While reset is applied, and until the first request after it, `done_rdy` is 0 and every bit of `child_val` is 0.
- R2: In idle, `child_val` and `done_rdy` are 0. A high `start_val` sampled at a rising edge makes `child_val` nonzero from that edge on.
- R3: In concurrent mode (PAR_MODE=1), while the group is running, every bit of `child_val` is 1.
- R4: In concurrent mode, `done_rdy` rises at the first edge at which every child's ready has been sampled high at least once since the start. The children may report in the same cycle or in different cycles.
- R5: In ordered mode (PAR_MODE=0), at most one `child_val` bit is high. The first child activated is bit 0.
- R6: In ordered mode, when `child_rdy[k]` is sampled high while `child_val[k]` is high and k < N_CHILD-1, then from that edge on `child_val` holds only bit k+1. When k = N_CHILD-1, `done_rdy` rises instead.
- R7: While `done_rdy` is high, every `child_val` bit is 0. `done_rdy` stays high for as long as `start_val` stays high.
- R8: When `start_val` is sampled low while `done_rdy` is high, `done_rdy` falls at that edge. A later `start_val` starts a new run.
- R9: In ordered mode, a ready from a child whose valid is low does not move the sequence, and `child_val` is unchanged at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| start_val | input | 1 | Request from the parent, held high until `done_rdy` has been seen |
| done_rdy | output | 1 | Group complete; held high until `start_val` falls |
| child_val | output | N_CHILD | Per-child activation |
| child_rdy | input | N_CHILD | Per-child completion, held while that child's valid is high |

## Verification
Two situations are hard to reach from the ports. The first is the concurrent case where children report ready in different cycles, so that the remembered ready bits, and not one common cycle, decide completion. The second is the ordered case where a ready pulse arrives on a child that is not active. The bench models each child with a random response latency, which staggers the ready edges. It adds directed runs where all latencies are equal, where they are strictly falling, and where a stray ready pulse is sent to the last child while an earlier child is still busy.

// File: rtl/grp_hs_pkg.sv
package grp_hs_pkg;

  // Controller phases: waiting for a request, children active, group reported done.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } grp_state_e;

endpackage

// File: rtl/grp_rst_sync.sv
module grp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shreg;

  // Reset is applied at once; its release passes through STAGES flops.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shreg <= '0;
    else         shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign srst_n = shreg[STAGES-1];
endmodule

// File: rtl/grp_done_tracker.sv
module grp_done_tracker #(
  parameter int N_CHILD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               capture,
  input  logic [N_CHILD-1:0] rdy_in,
  output logic               all_done
);
  logic [N_CHILD-1:0] seen_q, seen_d;
  logic               seen_en;

  // The sticky bits are loaded while running and cleared while idle.
  assign seen_en = clr | capture;

  always_comb begin
    seen_d = seen_q;
    if (clr)          seen_d = '0;
    else if (capture) seen_d = seen_q | rdy_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= '0;
    else if (seen_en) seen_q <= seen_d;
  end

  // The group counts as done in the cycle in which the last child reports.
  assign all_done = capture & (&(seen_q | rdy_in));
endmodule

// File: rtl/grp_seq_cursor.sv
module grp_seq_cursor #(
  parameter int N_CHILD = 4,
  localparam int IDX_W  = (N_CHILD > 1) ? $clog2(N_CHILD) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  output logic [IDX_W-1:0]   idx,
  output logic               at_last,
  output logic [N_CHILD-1:0] sel_onehot
);
  localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(N_CHILD - 1);
  localparam logic [N_CHILD-1:0] ONE_HOT0 = N_CHILD'(1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign idx_en = clr | step;

  always_comb begin
    idx_d = idx_q;
    if (clr)       idx_d = '0;
    else if (step) idx_d = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx        = idx_q;
  assign at_last    = (idx_q == LAST_IDX);
  assign sel_onehot = ONE_HOT0 << idx_q;
endmodule

// File: rtl/grp_handshake_ctrl.sv
module grp_handshake_ctrl
  import grp_hs_pkg::*;
#(
  parameter int N_CHILD  = 4,
  parameter bit PAR_MODE = 1'b1,
  parameter int SYNC_STG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_val,
  output logic               done_rdy,
  output logic [N_CHILD-1:0] child_val,
  input  logic [N_CHILD-1:0] child_rdy
);
  logic       rst_sync_n;
  grp_state_e state_q, state_d;
  logic       running, idle, group_done;
  logic [N_CHILD-1:0] run_val;

  grp_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  assign running = (state_q == ST_RUN);
  assign idle    = (state_q == ST_IDLE);

  generate
    if (PAR_MODE) begin : g_par
      // All children are active at once; completion needs every ready seen once.
      grp_done_tracker #(.N_CHILD(N_CHILD)) u_track (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .clr      (idle),
        .capture  (running),
        .rdy_in   (child_rdy),
        .all_done (group_done)
      );
      assign run_val = '1;
    end else begin : g_seq
      localparam int IDX_W = (N_CHILD > 1) ? $clog2(N_CHILD) : 1;
      logic [IDX_W-1:0]   cur_idx;
      logic               cur_last;
      logic               cur_rdy;
      logic [N_CHILD-1:0] cur_sel;

      // Only the active child's ready is looked at; the others are ignored.
      assign cur_rdy = running & child_rdy[cur_idx];

      grp_seq_cursor #(.N_CHILD(N_CHILD)) u_cursor (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .clr        (idle),
        .step       (cur_rdy & ~cur_last),
        .idx        (cur_idx),
        .at_last    (cur_last),
        .sel_onehot (cur_sel)
      );
      assign group_done = cur_rdy & cur_last;
      assign run_val    = cur_sel;
    end
  endgenerate

  // Next-state process.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_val)  state_d = ST_RUN;
      ST_RUN:  if (group_done) state_d = ST_DONE;
      ST_DONE: if (!start_val) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  // State register.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  // Output process: every output has a value in every state.
  always_comb begin
    child_val = '0;
    done_rdy  = 1'b0;
    unique case (state_q)
      ST_RUN:  child_val = run_val;
      ST_DONE: done_rdy  = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/grp_handshake_chk.sv
module grp_handshake_chk #(
  parameter int N_CHILD  = 4,
  parameter bit PAR_MODE = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_val,
  input logic               done_rdy,
  input logic [N_CHILD-1:0] child_val,
  input logic [N_CHILD-1:0] child_rdy
);
  // R1: outputs stay quiet while the internal reset is held.
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!done_rdy && child_val == '0)
        else $error("reset outputs not quiet");
    end
  end

  p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_rdy && child_val == '0 && start_val) |=> (child_val != '0));

  p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_rdy |-> (child_val == '0));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_rdy && start_val) |=> done_rdy);

  p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_rdy && !start_val) |=> (!done_rdy && child_val == '0));

  generate
    if (PAR_MODE) begin : g_par_chk
      p_par_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (child_val != '0) |-> (&child_val));
    end else begin : g_seq_chk
      p_seq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(child_val));

      p_seq_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (((child_val & child_rdy) != '0) && !child_val[N_CHILD-1])
          |=> (child_val == ($past(child_val) << 1)));

      p_seq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((child_val != '0) && ((child_val & child_rdy) == '0))
          |=> (child_val == $past(child_val)));
    end
  endgenerate
endmodule

bind grp_handshake_ctrl grp_handshake_chk #(
  .N_CHILD  (N_CHILD),
  .PAR_MODE (PAR_MODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start_val (start_val),
  .done_rdy  (done_rdy),
  .child_val (child_val),
  .child_rdy (child_rdy)
);

// File: tb/grp_handshake_ctrl_test.sv
module grp_handshake_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int LIMIT      = 2000;

  logic         clk;
  logic         rst_n;
  logic         p_start, s_start;
  logic         p_done,  s_done;
  logic [N-1:0] p_val,   s_val;
  logic [N-1:0] p_rdy,   s_rdy;

  int n_chk;
  int n_fail;
  int lat [N];

  grp_handshake_ctrl #(.N_CHILD(N), .PAR_MODE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start_val(p_start), .done_rdy(p_done),
    .child_val(p_val), .child_rdy(p_rdy)
  );

  grp_handshake_ctrl #(.N_CHILD(N), .PAR_MODE(1'b0)) uut_seq (
    .clk(clk), .rst_n(rst_n), .start_val(s_start), .done_rdy(s_done),
    .child_val(s_val), .child_rdy(s_rdy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected outputs in the done phase: the done flag concatenated above the valids.
  function automatic logic [31:0] done_word(input bit d, input logic [N-1:0] v);
    return {27'd0, d, v};
  endfunction

  // Done phase shared by both modes: hold start for 'hold' more cycles, then release.
  task automatic finish_phase(input bit par, input int hold);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (par) chk(p_done && p_val == '0, "R7", done_word(p_done, p_val), done_word(1, 0));
      else     chk(s_done && s_val == '0, "R7", done_word(s_done, s_val), done_word(1, 0));
      p_rdy = '0; s_rdy = '0;
    end
    if (par) p_start = 1'b0; else s_start = 1'b0;
    @(negedge clk);
    if (par) chk(!p_done && p_val == '0, "R8", done_word(p_done, p_val), 0);
    else     chk(!s_done && s_val == '0, "R8", done_word(s_done, s_val), 0);
  endtask

  // One concurrent-mode run using the latencies in lat[].
  task automatic run_par(input int hold);
    int cnt [N];
    bit ever [N];
    bit all_ever;
    int cyc;
    for (int i = 0; i < N; i++) begin cnt[i] = 0; ever[i] = 0; end
    p_start = 1'b1;
    cyc = 0;
    all_ever = 0;
    while (!all_ever && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      chk(p_val == '1 && !p_done, (cyc == 1) ? "R2" : "R3",
          done_word(p_done, p_val), done_word(0, '1));
      for (int i = 0; i < N; i++) begin
        if (p_val[i]) begin
          cnt[i]++;
          if (cnt[i] >= lat[i]) begin p_rdy[i] = 1'b1; ever[i] = 1; end
        end else begin
          cnt[i] = 0; p_rdy[i] = 1'b0;
        end
      end
      all_ever = 1;
      for (int i = 0; i < N; i++) all_ever &= ever[i];
    end
    if (cyc >= LIMIT) chk(0, "R4 watchdog", cyc, LIMIT);
    // The last ready was sampled at the edge just past; done must already be up.
    @(negedge clk);
    chk(p_done && p_val == '0, "R4", done_word(p_done, p_val), done_word(1, 0));
    p_rdy = '0;
    finish_phase(1'b1, hold);
  endtask

  // One ordered-mode run; a stray ready goes to the last child at cycle stray_at.
  task automatic run_seq(input int hold, input int stray_at);
    int e;
    int cnt;
    int cyc;
    bit stray_prev;
    e = 0; cnt = 0; cyc = 0; stray_prev = 0;
    s_start = 1'b1;
    while (e < N && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      chk(s_val == (N'(1) << e) && !s_done,
          stray_prev ? "R9" : ((cyc == 1) ? "R5" : "R6"),
          done_word(s_done, s_val), done_word(0, N'(1) << e));
      stray_prev = 0;
      for (int i = 0; i < N; i++) if (i != e) s_rdy[i] = 1'b0;
      if (s_val[e]) begin
        cnt++;
        if (cnt >= lat[e]) begin
          s_rdy[e] = 1'b1;
          e++;
          cnt = 0;
        end
      end
      if (cyc == stray_at && e < N - 1) begin
        s_rdy[N-1] = 1'b1;
        stray_prev = 1;
      end
    end
    if (cyc >= LIMIT) chk(0, "R6 watchdog", cyc, LIMIT);
    @(negedge clk);
    chk(s_done && s_val == '0, "R6", done_word(s_done, s_val), done_word(1, 0));
    s_rdy = '0;
    finish_phase(1'b0, hold);
  endtask

  task automatic idle_check(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      chk(!p_done && p_val == '0, "R2", done_word(p_done, p_val), 0);
      chk(!s_done && s_val == '0, "R2", done_word(s_done, s_val), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; p_start = 1'b0; s_start = 1'b0; p_rdy = '0; s_rdy = '0;
    // R1: quiet during reset, even with a request pending.
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      p_start = 1'b1; s_start = 1'b1;
      chk(!p_done && p_val == '0 && !s_done && s_val == '0, "R1",
          done_word(p_done | s_done, p_val | s_val), 0);
    end
    p_start = 1'b0; s_start = 1'b0;
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!p_done && p_val == '0 && !s_done && s_val == '0, "R1",
          done_word(p_done | s_done, p_val | s_val), 0);
    end

    // Directed: every child answers at once.
    for (int i = 0; i < N; i++) lat[i] = 1;
    run_par(0);
    run_seq(0, 0);
    idle_check(2);
    // Directed: falling latencies, last child finishes first.
    for (int i = 0; i < N; i++) lat[i] = N - i + 2;
    run_par(3);
    run_seq(2, 2);
    // Directed: back to back with a stray ready injected early.
    for (int i = 0; i < N; i++) lat[i] = 5;
    run_seq(1, 3);
    run_seq(0, 1);

    // Random latencies and hold lengths.
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < N; i++) lat[i] = 1 + int'($urandom_range(9));
      run_par(int'($urandom_range(4)));
      if ($urandom_range(1) == 1) idle_check(1);
      for (int i = 0; i < N; i++) lat[i] = 1 + int'($urandom_range(6));
      run_seq(int'($urandom_range(4)), 1 + int'($urandom_range(8)));
    end
    idle_check(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule